// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block turns completion events from a set of DMA channels into one interrupt line. Each channel has a small status register. Event pulses set bits in it. A per-channel control register selects which of those bits count. When a channel has at least one selected status bit set, its bit in a global pending register is set. A global enable register then decides whether that pending bit drives the interrupt output.

Software reaches every register through a flat address/data port. Writes complete in one cycle and reads are combinational. Global registers sit at the bottom of the address space. Each channel owns a 0x100-byte window: channel i starts at 0x100·(i+1), with its control word at window offset 0x40 and its status word at 0x44. There are four pending/enable pairs, but only the first pair drives the interrupt. The other three pairs are plain read/write storage. A read-only word reports the channels' idle flags.

Top module: `irq_aggregator`

## Requirements
- R1: Each channel has five event inputs on `evt_i` bits [5i+4:5i]: bit 0 block done, bit 1 super-block done, bit 2 frame done, bit 3 half frame, bit 4 last frame. A pulse on event bit k sets bit k of that channel's status word at 0x100·(i+1)+0x44 at the next clock edge, and no other channel's status changes.
- R2: A write to a status word clears each status bit written as 0 and leaves each bit written as 1 unchanged.
- R3: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R4: The control word at 0x100·(i+1)+0x40 stores write data bits [4:0] and reads back those bits. Its upper bits read as zero.
- R5: Bit i of group-0 pending (offset 0x00) is set one cycle after (control AND status) of channel i becomes nonzero. A status bit whose control bit is 0 never sets it.
- R6: Writing 1 to a group-0 pending bit clears it, unless channel i still has a selected status bit, in which case the bit stays set. Writing 0 has no effect.
- R7: `irq_o` is high exactly when some channel has both its group-0 pending bit and its group-0 enable bit (offset 0x10) set.
- R8: Pending words at 0x04, 0x08, 0x0C and enable words at 0x10, 0x14, 0x18, 0x1C store bits [NUM_CH-1:0] of the write data and read them back. The groups other than 0 never affect `irq_o`.
- R9: The word at 0x2C reads `idle_i` in bits [NUM_CH-1:0].
- R10: Reads change no state. Any unmapped offset, and any channel window beyond NUM_CH, reads as zero.
- R11: After reset, every register reads zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_CH*5 | Per-channel event pulses, five bits per channel |
| idle_i | input | NUM_CH | Per-channel idle flags for the idle word |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench sweeps every event bit of every channel through the full path:
- first with the control bit off, where a design that ignored the mask would raise pending;
- then with it on, through enable gating and the two clear steps.

It writes a clear to a pending bit while the channel's condition still holds; a design that cleared without re-setting would drop the interrupt.

It fires an event in the same cycle as a status-clearing write; a design that gave the write priority would lose the event.

It fills the unused groups with ones to catch leakage into `irq_o`. It reads beyond the last channel window to catch address aliasing.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int EVT_W     = 5;
   localparam int NUM_GRP   = 4;
   localparam logic [7:0] OFS_PEND  = 8'h00;
   localparam logic [7:0] OFS_EN    = 8'h10;
   localparam logic [7:0] OFS_IDLE  = 8'h2C;
   localparam logic [7:0] OFS_CCTRL = 8'h40;
   localparam logic [7:0] OFS_CSTAT = 8'h44;

   typedef enum int {
      EV_BLOCK  = 0,
      EV_SUPER  = 1,
      EV_FRAME  = 2,
      EV_HALF   = 3,
      EV_LAST   = 4
   } evt_bit_e;
endpackage

// File: rtl/irq_agg_chan.sv
module irq_agg_chan #(
   parameter int EVT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] evt,
   input  logic             ctrl_we,
   input  logic             stat_we,
   input  logic [EVT_W-1:0] wdata,
   output logic [EVT_W-1:0] ctrl_q,
   output logic [EVT_W-1:0] stat_q,
   output logic             hit
);
   logic [EVT_W-1:0] keep_mask;

   // a status write keeps only the bits written as 1; events always win
   assign keep_mask = stat_we ? wdata : {EVT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         stat_q <= '0;
      end else begin
         if (ctrl_we) ctrl_q <= wdata;
         stat_q <= (stat_q & keep_mask) | evt;
      end
   end

   assign hit = |(ctrl_q & stat_q);
endmodule

// File: rtl/irq_agg_glb.sv
module irq_agg_glb #(
   parameter int NUM_CH  = 4,
   parameter int NUM_GRP = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_GRP-1:0]              pend_we,
   input  logic [NUM_GRP-1:0]              en_we,
   input  logic [NUM_CH-1:0]               wdata,
   input  logic [NUM_CH-1:0]               chan_hit,
   output logic [NUM_GRP-1:0][NUM_CH-1:0]  pend_q,
   output logic [NUM_GRP-1:0][NUM_CH-1:0]  en_q
);
   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        en_q[g] <= '0;
         else if (en_we[g]) en_q[g] <= wdata;
      end

      if (g == 0) begin : g_live
         logic [NUM_CH-1:0] clr;
         assign clr = pend_we[g] ? wdata : '0;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q[g] <= '0;
            else        pend_q[g] <= (pend_q[g] & ~clr) | chan_hit;
         end
      end else begin : g_store
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          pend_q[g] <= '0;
            else if (pend_we[g]) pend_q[g] <= wdata;
         end
      end
   end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irq_agg_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_CH*EVT_W-1:0] evt_i,
   input  logic [NUM_CH-1:0]       idle_i,
   input  logic                    bus_we,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   output logic                    irq_o
);
   localparam int WIN_W = ADDR_W - 8;

   if (NUM_CH < 1 || NUM_CH > DATA_W) begin : g_bad_ch
      $error("NUM_CH must lie in 1..DATA_W");
   end
   if (WIN_W < 1 || (2 ** WIN_W) <= NUM_CH) begin : g_bad_addr
      $error("ADDR_W too small for NUM_CH channel windows");
   end
   if (DATA_W < EVT_W) begin : g_bad_data
      $error("DATA_W narrower than event field");
   end

   logic [WIN_W-1:0] win;
   logic [7:0]       ofs;
   logic             glb_sel;
   assign win     = bus_addr[ADDR_W-1:8];
   assign ofs     = bus_addr[7:0];
   assign glb_sel = (win == '0);

   logic                            unused_wdata;
   assign unused_wdata = ^bus_wdata;

   logic [NUM_CH-1:0]               chan_hit;
   logic [NUM_CH*EVT_W-1:0]         stat_flat;
   logic [NUM_CH*EVT_W-1:0]         ctrl_flat;
   logic [NUM_GRP-1:0][NUM_CH-1:0]  pend_q, en_q;
   logic [NUM_GRP-1:0]              pend_we, en_we;
   logic [NUM_CH-1:0]               pend0, en0;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic sel;
      assign sel = (win == WIN_W'(i + 1));
      irq_agg_chan #(.EVT_W(EVT_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .evt     (evt_i[i*EVT_W +: EVT_W]),
         .ctrl_we (bus_we && sel && ofs == OFS_CCTRL),
         .stat_we (bus_we && sel && ofs == OFS_CSTAT),
         .wdata   (bus_wdata[EVT_W-1:0]),
         .ctrl_q  (ctrl_flat[i*EVT_W +: EVT_W]),
         .stat_q  (stat_flat[i*EVT_W +: EVT_W]),
         .hit     (chan_hit[i])
      );
   end

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_dec
      assign pend_we[g] = bus_we && glb_sel && ofs == OFS_PEND + 8'(4 * g);
      assign en_we[g]   = bus_we && glb_sel && ofs == OFS_EN   + 8'(4 * g);
   end

   irq_agg_glb #(.NUM_CH(NUM_CH), .NUM_GRP(NUM_GRP)) u_glb (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend_we  (pend_we),
      .en_we    (en_we),
      .wdata    (bus_wdata[NUM_CH-1:0]),
      .chan_hit (chan_hit),
      .pend_q   (pend_q),
      .en_q     (en_q)
   );

   assign pend0 = pend_q[0];
   assign en0   = en_q[0];
   assign irq_o = |(pend0 & en0);

   always_comb begin
      bus_rdata = '0;
      if (glb_sel) begin
         for (int g = 0; g < NUM_GRP; g++) begin
            if (ofs == OFS_PEND + 8'(4 * g)) bus_rdata[NUM_CH-1:0] = pend_q[g];
            if (ofs == OFS_EN   + 8'(4 * g)) bus_rdata[NUM_CH-1:0] = en_q[g];
         end
         if (ofs == OFS_IDLE) bus_rdata[NUM_CH-1:0] = idle_i;
      end else begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (win == WIN_W'(i + 1)) begin
               if (ofs == OFS_CCTRL) bus_rdata[EVT_W-1:0] = ctrl_flat[i*EVT_W +: EVT_W];
               if (ofs == OFS_CSTAT) bus_rdata[EVT_W-1:0] = stat_flat[i*EVT_W +: EVT_W];
            end
         end
      end
   end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
   parameter int NUM_CH = 4,
   parameter int EVT_W  = 5
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    irq_o,
   input logic [NUM_CH-1:0]       pend0,
   input logic [NUM_CH-1:0]       en0,
   input logic [NUM_CH-1:0]       chan_hit,
   input logic [NUM_CH*EVT_W-1:0] evt_i,
   input logic [NUM_CH*EVT_W-1:0] stat_flat
);
   // R3
   evt_never_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i != '0) |=> ((stat_flat & $past(evt_i)) == $past(evt_i)));

   // R1
   stat_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_flat & ~$past(stat_flat) & ~$past(evt_i)) == '0));

   // R5
   hit_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_hit != '0) |=> ((pend0 & $past(chan_hit)) == $past(chan_hit)));

   // R6
   pend_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend0 & ~$past(pend0) & ~$past(chan_hit)) == '0));

   // R7
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en0 == '0) |-> !irq_o);
endmodule

bind irq_aggregator irq_aggregator_chk #(.NUM_CH(NUM_CH), .EVT_W(EVT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_o     (irq_o),
   .pend0     (pend0),
   .en0       (en0),
   .chan_hit  (chan_hit),
   .evt_i     (evt_i),
   .stat_flat (stat_flat)
);

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;
   localparam int NCH = 4;
   localparam int EW  = 5;
   localparam int AW  = 12;

   logic              clk = 0;
   logic              rst_n = 0;
   logic [NCH*EW-1:0] evt_i = '0;
   logic [NCH-1:0]    idle_i = '0;
   logic              bus_we = 0;
   logic [AW-1:0]     bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              irq_o;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   irq_aggregator #(.NUM_CH(NCH), .ADDR_W(AW), .DATA_W(32)) i_irq_aggregator (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .idle_i(idle_i),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   function automatic logic [AW-1:0] cw(int ch, int o);
      return AW'(32'h100 * (ch + 1) + o);
   endfunction

   task automatic chk(logic [31:0] act, logic [31:0] exp, string req);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [31:0] d);
      @(negedge clk);
      bus_we = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 0;
   endtask

   task automatic rd_chk(logic [AW-1:0] a, logic [31:0] exp, string req);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(bus_rdata, exp, req);
   endtask

   task automatic pulse(int ch, int b);
      @(negedge clk);
      evt_i = '0;
      evt_i[ch*EW + b] = 1'b1;
      @(posedge clk); #1;
      evt_i = '0;
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic irq_chk(logic exp, string req);
      @(negedge clk);
      chk({31'd0, irq_o}, {31'd0, exp}, req);
   endtask

   initial begin
      #150000;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R11 reset state
      for (int g = 0; g < 8; g++) rd_chk(AW'(4 * g), 0, "R11 global");
      for (int c = 0; c < NCH; c++) begin
         rd_chk(cw(c, 'h40), 0, "R11 ctrl");
         rd_chk(cw(c, 'h44), 0, "R11 stat");
      end
      irq_chk(0, "R11 irq");

      // R4 control storage
      for (int c = 0; c < NCH; c++) begin
         wr(cw(c, 'h40), 32'hFFFF_FFE0 | 32'(c + 9));
         rd_chk(cw(c, 'h40), 32'(c + 9) & 32'h1F, "R4 ctrl readback");
      end
      for (int c = 0; c < NCH; c++) wr(cw(c, 'h40), 0);

      // main sweep: every channel, every event bit
      for (int c = 0; c < NCH; c++) begin
         for (int b = 0; b < EW; b++) begin
            int b2 = (b + 1) % EW;
            pulse(c, b);
            for (int o = 0; o < NCH; o++)
               rd_chk(cw(o, 'h44), (o == c) ? (32'd1 << b) : 0, "R1 status set");
            tick();
            rd_chk(AW'(0), 0, "R5 masked no pending");
            wr(cw(c, 'h40), 32'd1 << b);
            tick();
            rd_chk(AW'(0), 32'd1 << c, "R5 pending set");
            irq_chk(0, "R7 disabled");
            wr(AW'('h10), 32'd1 << c);
            irq_chk(1, "R7 enabled");
            wr(AW'('h10), ~(32'd1 << c) & 32'hF);
            irq_chk(0, "R7 other enables");
            wr(AW'('h10), 32'd1 << c);
            wr(AW'(0), 32'd1 << c);
            tick();
            rd_chk(AW'(0), 32'd1 << c, "R6 held while hit");
            pulse(c, b2);
            wr(cw(c, 'h44), 32'd1 << b2);
            rd_chk(cw(c, 'h44), 32'd1 << b2, "R2 write one keeps");
            wr(cw(c, 'h44), 0);
            rd_chk(cw(c, 'h44), 0, "R2 write zero clears");
            wr(AW'(0), 0);
            rd_chk(AW'(0), 32'd1 << c, "R6 write zero no effect");
            wr(AW'(0), 32'd1 << c);
            rd_chk(AW'(0), 0, "R6 cleared");
            irq_chk(0, "R7 low after clear");
            wr(AW'('h10), 0);
            wr(cw(c, 'h40), 0);
         end
      end

      // R3 event and clearing write in the same cycle
      wr(cw(1, 'h40), 0);
      @(negedge clk);
      bus_we = 1; bus_addr = cw(1, 'h44); bus_wdata = 0;
      evt_i[1*EW + 2] = 1'b1;
      @(posedge clk); #1;
      bus_we = 0; evt_i = '0;
      rd_chk(cw(1, 'h44), 32'h4, "R3 event wins");
      wr(cw(1, 'h44), 0);

      // R8 other groups are storage only
      for (int g = 1; g < 4; g++) begin
         wr(AW'(4 * g), 32'hFFFF_FFF0 | 32'(g + 2));
         wr(AW'('h10 + 4 * g), 32'hF);
      end
      for (int g = 1; g < 4; g++) begin
         rd_chk(AW'(4 * g), 32'(g + 2) & 32'hF, "R8 pend readback");
         rd_chk(AW'('h10 + 4 * g), 32'hF, "R8 enable readback");
      end
      wr(AW'('h10), 32'hF);
      rd_chk(AW'('h10), 32'hF, "R8 enable0 readback");
      irq_chk(0, "R8 no irq from other groups");
      wr(AW'('h10), 0);

      // R9 idle word
      for (int v = 0; v < 16; v += 5) begin
         idle_i = NCH'(v);
         rd_chk(AW'('h2C), 32'(v), "R9 idle");
      end

      // R10 unmapped reads and read side effects
      pulse(2, 0);
      rd_chk(AW'('h30), 0, "R10 unmapped global");
      rd_chk(AW'('h500), 0, "R10 window past last channel");
      rd_chk(cw(2, 'h48), 0, "R10 unmapped channel");
      rd_chk(cw(2, 'h44), 1, "R10 read no side effect a");
      rd_chk(cw(2, 'h44), 1, "R10 read no side effect b");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule